// File: doc/BRIEF.md
# NAND Flash Bus Cycle Controller

This block sits between a simple 32-bit word-addressed register bus and the pins of an 8-bit raw NAND flash device. Software writes a command byte or an address byte to a dedicated register, and the block drives one latch cycle with the command-latch or address-latch pin raised. A write to the data register drives one write-strobe cycle carrying the low byte. A read of the data register drives one read-strobe cycle and returns the sampled byte once that cycle has finished. Every bus cycle runs through four phases: setup, strobe, hold and a ready-wait. The lengths come from a timing register that holds separate read and write sets.

Chip enable is asserted for the whole of each bus cycle. A configuration bit can also hold it asserted while the bus is idle, so that a command, its addresses and its data form one continuous chip selection. The block synchronises the ready/busy pin and reports it as status. It keeps a byte counter that counts down once for each data byte. Two interrupt sources are latched: the ready pin rising and the counter reaching zero. Each source can be masked and is cleared by writing 1. A self-clearing software reset returns the register state to its defaults.

Top module: `nand_bus_ctrl`

## Requirements
- R1: After reset `nand_ce_n`, `nand_we_n` and `nand_re_n` are high, `nand_cle`, `nand_ale`, `nand_io_oe` and `irq` are low, and with `nand_rb` high the status register (word 6) reads bit 0 = 1 within three clocks.
- R2: A write to word 2 runs one bus cycle with `nand_cle` high through setup, strobe and hold. `nand_io_oe` is high in those phases with the written low byte on `nand_io_out`, and `nand_we_n` is low only during the strobe. Write timings are used.
- R3: A write to word 1 runs the same kind of cycle with `nand_ale` high instead of `nand_cle`.
- R4: A write to word 0 runs a write-strobe cycle with both latch pins low and the low byte driven.
- R5: A read of word 0 runs a cycle with `nand_re_n` low during the strobe and `nand_io_oe` low. The bus is acknowledged in the last clock of that cycle, with the byte sampled in the last strobe clock in bits 7:0 and zeros above. Read timings are used.
- R6: The timing register (word 11) holds eight 4-bit fields, bits 3:0 upward: read setup, read hold, read width, read ready-wait, then write setup, write hold, write width, write ready-wait. Setup, strobe and hold each last their field value in clocks, and a value of 0 gives 1 clock.
- R7: After hold, the ready-wait phase lasts exactly its field value in clocks, with strobes high and no output enable. While any cycle is in progress, status bit 0 reads 0.
- R8: Any register write that arrives while a cycle is in progress is not acknowledged until that cycle has ended. Back-to-back cycles therefore start setup+width+hold+wait+1 clocks apart, with each phase counted as at least 1.
- R9: Configuration bit 5 (word 5) set keeps `nand_ce_n` low while the bus is idle. When it is clear, `nand_ce_n` is low only during a cycle.
- R10: The byte counter (word 12) decrements by one at the end of each data read or write cycle while it is nonzero. The step from 1 to 0 sets interrupt status bit 1 (word 7).
- R11: Interrupt status bit 0 is set when the synchronised ready pin rises. Writing 1s to word 10 clears those status bits. `irq` is high exactly when status AND enable (word 8) is nonzero.
- R12: Writing word 4 with bit 2 set clears configuration, timing, byte counter, interrupt enable and interrupt status. Word 4 reads back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Register access request, held until acknowledged |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| bus_ack | output | 1 | Access completes at this clock |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | 8 | Byte driven to flash |
| nand_io_oe | output | 1 | Output enable for nand_io_out |
| nand_io_in | input | 8 | Byte from flash |
| nand_rb | input | 1 | Ready (1) / busy (0) pin |
| irq | output | 1 | Masked interrupt request |

## Verification
The bench compares every pin and the acknowledge against a queue-driven model on every clock, so a phase that is one clock too long or too short shows up as a mismatch on the strobe. The most important corner is zero timing fields: a design that let a 0 field mean zero clocks would skip the strobe. Back-to-back writes are timed to show that a design which failed to stall would overlap two cycles. The bench also checks the byte counter's step to zero, write-one-to-clear against masking, and the software reset clearing state that a lax design would keep.

// File: rtl/nand_bus_pkg.sv
package nand_bus_pkg;
  localparam int unsigned TF_W = 4;

  typedef enum logic [1:0] {OP_CMD, OP_ADDR, OP_WR, OP_RD} nand_op_e;
  typedef enum logic [2:0] {PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD, PH_WAIT} nand_phase_e;

  typedef struct packed {
    logic [TF_W-1:0] setup;
    logic [TF_W-1:0] hold;
    logic [TF_W-1:0] width;
    logic [TF_W-1:0] rwait;
  } phase_times_t;

  localparam logic [3:0] REG_DATA = 4'd0;
  localparam logic [3:0] REG_ADDR = 4'd1;
  localparam logic [3:0] REG_CMD  = 4'd2;
  localparam logic [3:0] REG_CTRL = 4'd4;
  localparam logic [3:0] REG_CFG  = 4'd5;
  localparam logic [3:0] REG_STAT = 4'd6;
  localparam logic [3:0] REG_INT  = 4'd7;
  localparam logic [3:0] REG_IEN  = 4'd8;
  localparam logic [3:0] REG_IMSK = 4'd9;
  localparam logic [3:0] REG_ICLR = 4'd10;
  localparam logic [3:0] REG_TIME = 4'd11;
  localparam logic [3:0] REG_TCNT = 4'd12;
endpackage

// File: rtl/nand_rb_sync.sv
module nand_rb_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic sync_o
);
  logic [STAGES-1:0] stg_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[i] <= 1'b1;
        else if (i == 0) stg_q[i] <= pin_i;
        else stg_q[i] <= stg_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/nand_cycle_engine.sv
module nand_cycle_engine
  import nand_bus_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  nand_op_e     op_i,
  input  logic [7:0]   byte_i,
  input  phase_times_t times_i,
  input  logic [7:0]   io_in_i,
  output logic         busy_o,
  output logic         done_o,
  output nand_op_e     op_o,
  output logic [7:0]   rd_byte_o,
  output logic         cle_o,
  output logic         ale_o,
  output logic         we_n_o,
  output logic         re_n_o,
  output logic         io_oe_o,
  output logic [7:0]   io_out_o
);
  nand_phase_e     phase_q, phase_d;
  logic [TF_W-1:0] cnt_q, cnt_d, len_m1;
  nand_op_e        op_q;
  logic [7:0]      byte_q, rd_q;
  phase_times_t    tim_q;
  logic            last, lat_en, cap_en, active;

  function automatic logic [TF_W-1:0] min1_m1(input logic [TF_W-1:0] f);
    return (f == '0) ? '0 : f - 1'b1;
  endfunction

  always_comb begin
    case (phase_q)
      PH_SETUP:  len_m1 = min1_m1(tim_q.setup);
      PH_STROBE: len_m1 = min1_m1(tim_q.width);
      PH_HOLD:   len_m1 = min1_m1(tim_q.hold);
      PH_WAIT:   len_m1 = tim_q.rwait - 1'b1;
      default:   len_m1 = '0;
    endcase
    last = (cnt_q == len_m1);
  end

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    done_o  = 1'b0;
    case (phase_q)
      PH_IDLE: if (start_i) begin phase_d = PH_SETUP; cnt_d = '0; end
      PH_SETUP: begin
        if (last) begin phase_d = PH_STROBE; cnt_d = '0; end
        else cnt_d = cnt_q + 1'b1;
      end
      PH_STROBE: begin
        if (last) begin phase_d = PH_HOLD; cnt_d = '0; end
        else cnt_d = cnt_q + 1'b1;
      end
      PH_HOLD: begin
        if (last) begin
          cnt_d = '0;
          if (tim_q.rwait != '0) phase_d = PH_WAIT;
          else begin phase_d = PH_IDLE; done_o = 1'b1; end
        end else cnt_d = cnt_q + 1'b1;
      end
      PH_WAIT: begin
        if (last) begin phase_d = PH_IDLE; cnt_d = '0; done_o = 1'b1; end
        else cnt_d = cnt_q + 1'b1;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  assign lat_en = start_i && (phase_q == PH_IDLE);
  assign cap_en = (phase_q == PH_STROBE) && last && (op_q == OP_RD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_CMD;
      byte_q <= '0;
      tim_q  <= '0;
    end else if (lat_en) begin
      op_q   <= op_i;
      byte_q <= byte_i;
      tim_q  <= times_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else if (cap_en) rd_q <= io_in_i;
  end

  assign active    = (phase_q == PH_SETUP) || (phase_q == PH_STROBE) || (phase_q == PH_HOLD);
  assign busy_o    = (phase_q != PH_IDLE);
  assign op_o      = op_q;
  assign rd_byte_o = rd_q;
  assign cle_o     = active && (op_q == OP_CMD);
  assign ale_o     = active && (op_q == OP_ADDR);
  assign we_n_o    = !((phase_q == PH_STROBE) && (op_q != OP_RD));
  assign re_n_o    = !((phase_q == PH_STROBE) && (op_q == OP_RD));
  assign io_oe_o   = active && (op_q != OP_RD);
  assign io_out_o  = byte_q;

  p_strobe_after_setup_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_STROBE && cnt_q == '0) |-> ($past(phase_q) == PH_SETUP));
  p_byte_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (io_oe_o && $past(io_oe_o)) |-> $stable(io_out_o));
  p_done_to_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (phase_q == PH_IDLE));
endmodule

// File: rtl/nand_ctl_regs.sv
module nand_ctl_regs
  import nand_bus_pkg::*;
#(
  parameter int unsigned TC_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en_i,
  input  logic [3:0]  addr_i,
  input  logic [31:0] wdata_i,
  input  logic        byte_done_i,
  input  logic        rb_sync_i,
  input  logic        busy_i,
  input  logic [7:0]  rd_byte_i,
  output logic [31:0] rdata_o,
  output logic        ce_hold_o,
  output logic [31:0] tac_o,
  output logic        irq_o
);
  localparam int unsigned CFG_W = 6;
  localparam int unsigned INT_W = 2;

  logic [CFG_W-1:0] cfg_q, cfg_d;
  logic [31:0]      tac_q, tac_d;
  logic [INT_W-1:0] ien_q, ien_d, int_q, int_d, int_set;
  logic [TC_W-1:0]  tc_q, tc_d;
  logic             rbp_q, soft_rst, wr_tc, tc_hit;

  assign soft_rst = wr_en_i && (addr_i == REG_CTRL) && wdata_i[2];
  assign wr_tc    = wr_en_i && (addr_i == REG_TCNT);
  assign tc_hit   = byte_done_i && (tc_q == TC_W'(1)) && !wr_tc;

  always_comb begin
    cfg_d = cfg_q;
    tac_d = tac_q;
    ien_d = ien_q;
    tc_d  = tc_q;
    int_set = {tc_hit, rb_sync_i && !rbp_q};
    int_d = int_q;
    if (wr_en_i && addr_i == REG_CFG)  cfg_d = wdata_i[CFG_W-1:0];
    if (wr_en_i && addr_i == REG_TIME) tac_d = wdata_i;
    if (wr_en_i && addr_i == REG_IEN)  ien_d = wdata_i[INT_W-1:0];
    if (wr_tc) tc_d = wdata_i[TC_W-1:0];
    else if (byte_done_i && tc_q != '0) tc_d = tc_q - 1'b1;
    if (wr_en_i && addr_i == REG_ICLR) int_d = int_d & ~wdata_i[INT_W-1:0];
    int_d = int_d | int_set;
    if (soft_rst) begin
      cfg_d = '0; tac_d = '0; ien_d = '0; tc_d = '0; int_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      tac_q <= '0;
      ien_q <= '0;
      int_q <= '0;
      tc_q  <= '0;
      rbp_q <= 1'b1;
    end else begin
      cfg_q <= cfg_d;
      tac_q <= tac_d;
      ien_q <= ien_d;
      int_q <= int_d;
      tc_q  <= tc_d;
      rbp_q <= rb_sync_i;
    end
  end

  always_comb begin
    case (addr_i)
      REG_DATA: rdata_o = {24'd0, rd_byte_i};
      REG_CFG:  rdata_o = 32'(cfg_q);
      REG_STAT: rdata_o = {31'd0, rb_sync_i && !busy_i};
      REG_INT:  rdata_o = 32'(int_q);
      REG_IEN:  rdata_o = 32'(ien_q);
      REG_IMSK: rdata_o = 32'(int_q & ien_q);
      REG_TIME: rdata_o = tac_q;
      REG_TCNT: rdata_o = 32'(tc_q);
      default:  rdata_o = '0;
    endcase
  end

  assign ce_hold_o = cfg_q[5];
  assign tac_o     = tac_q;
  assign irq_o     = |(int_q & ien_q);

  p_tc_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done_i && tc_q != '0 && !wr_en_i) |=> (tc_q == $past(tc_q) - 1'b1));
  p_tc_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_q[1]) |-> ($past(tc_q) == TC_W'(1)));
endmodule

// File: rtl/nand_bus_ctrl.sv
module nand_bus_ctrl
  import nand_bus_pkg::*;
#(
  parameter int unsigned TC_W    = 16,
  parameter int unsigned SYNC_N  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_req,
  input  logic        bus_we,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        bus_ack,
  output logic        nand_ce_n,
  output logic        nand_cle,
  output logic        nand_ale,
  output logic        nand_we_n,
  output logic        nand_re_n,
  output logic [7:0]  nand_io_out,
  output logic        nand_io_oe,
  input  logic [7:0]  nand_io_in,
  input  logic        nand_rb,
  output logic        irq
);
  localparam int unsigned HALF = 16;

  logic         busy, done, rb_sync, ce_hold, rd_pend_q, rd_pend_d;
  logic         wr_acc, rd_start, start, cyc_reg, byte_done;
  logic [7:0]   rd_byte;
  logic [31:0]  tac;
  nand_op_e     op_sel, eng_op;
  phase_times_t t_sel;

  assign cyc_reg  = (bus_addr == REG_DATA) || (bus_addr == REG_ADDR) || (bus_addr == REG_CMD);
  assign wr_acc   = bus_req && bus_we && !busy;
  assign rd_start = bus_req && !bus_we && (bus_addr == REG_DATA) && !busy && !rd_pend_q;
  assign start    = (wr_acc && cyc_reg) || rd_start;

  always_comb begin
    if (!bus_we)                  op_sel = OP_RD;
    else if (bus_addr == REG_CMD) op_sel = OP_CMD;
    else if (bus_addr == REG_ADDR) op_sel = OP_ADDR;
    else                          op_sel = OP_WR;
  end

  always_comb begin
    logic [HALF-1:0] h;
    h = (op_sel == OP_RD) ? tac[HALF-1:0] : tac[2*HALF-1:HALF];
    t_sel.setup = h[3:0];
    t_sel.hold  = h[7:4];
    t_sel.width = h[11:8];
    t_sel.rwait = h[15:12];
  end

  always_comb begin
    rd_pend_d = rd_pend_q;
    if (rd_start) rd_pend_d = 1'b1;
    else if (done) rd_pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_pend_q <= 1'b0;
    else rd_pend_q <= rd_pend_d;
  end

  assign bus_ack   = wr_acc || (bus_req && !bus_we && bus_addr != REG_DATA) || (rd_pend_q && done);
  assign byte_done = done && (eng_op == OP_WR || eng_op == OP_RD);

  nand_rb_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(nand_rb), .sync_o(rb_sync)
  );

  nand_cycle_engine u_eng (
    .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op_sel),
    .byte_i(bus_wdata[7:0]), .times_i(t_sel), .io_in_i(nand_io_in),
    .busy_o(busy), .done_o(done), .op_o(eng_op), .rd_byte_o(rd_byte),
    .cle_o(nand_cle), .ale_o(nand_ale), .we_n_o(nand_we_n), .re_n_o(nand_re_n),
    .io_oe_o(nand_io_oe), .io_out_o(nand_io_out)
  );

  nand_ctl_regs #(.TC_W(TC_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_acc), .addr_i(bus_addr),
    .wdata_i(bus_wdata), .byte_done_i(byte_done), .rb_sync_i(rb_sync),
    .busy_i(busy), .rd_byte_i(rd_byte), .rdata_o(bus_rdata),
    .ce_hold_o(ce_hold), .tac_o(tac), .irq_o(irq)
  );

  assign nand_ce_n = !(ce_hold || busy);

  p_ce_with_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n || !nand_re_n) |-> !nand_ce_n);
  p_read_ack_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ack && !bus_we && bus_addr == REG_DATA) |=> !busy);
endmodule

// File: tb/nand_bus_ctrl_test.sv
`timescale 1ns/1ps
module nand_bus_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_req = 1'b0, bus_we = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic bus_ack, nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe, irq;
  logic [7:0] nand_io_out;
  logic [7:0] nand_io_in = 8'h00;
  logic nand_rb = 1'b1;

  int nerr = 0, nchk = 0, cyc = 0;

  always #10 clk = ~clk;

  nand_bus_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_io_out(nand_io_out),
    .nand_io_oe(nand_io_oe), .nand_io_in(nand_io_in), .nand_rb(nand_rb), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference model: entry bits [9:8] op, [7] last, [6] busy, [5] cle, [4] ale, [3] we_n, [2] re_n, [1] oe
  localparam logic [9:0] IDLE_E = 10'b00_0000_1100;
  logic [9:0] q[$];
  logic [9:0] cur = IDLE_E;
  logic [31:0] m_tac = '0;
  logic m_hold = 1'b0, m_rdpend = 1'b0;
  logic [7:0] m_byte = '0;

  task automatic push_cycle(input int op);
    int base, s, w, h, r;
    logic [9:0] e;
    base = (op == 3) ? 0 : 16;
    s = m_tac[base +: 4];     if (s == 0) s = 1;
    h = m_tac[base+4 +: 4];   if (h == 0) h = 1;
    w = m_tac[base+8 +: 4];   if (w == 0) w = 1;
    r = m_tac[base+12 +: 4];
    for (int i = 0; i < s + w + h + r; i++) begin
      e = '0;
      e[9:8] = 2'(op);
      e[6] = 1'b1;
      e[3] = 1'b1; e[2] = 1'b1;
      if (i < s + w + h) begin
        e[5] = (op == 0); e[4] = (op == 1); e[1] = (op != 3);
        if (i >= s && i < s + w) begin
          if (op == 3) e[2] = 1'b0; else e[3] = 1'b0;
        end
      end
      if (i == s + w + h + r - 1) e[7] = 1'b1;
      q.push_back(e);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      q.delete(); cur = IDLE_E; m_tac = '0; m_hold = 1'b0; m_rdpend = 1'b0;
    end else begin
      if (cur[7] && m_rdpend) m_rdpend = 1'b0;
      if (bus_req && bus_we && !cur[6]) begin
        if (bus_addr == 4'd11) m_tac = bus_wdata;
        if (bus_addr == 4'd5) m_hold = bus_wdata[5];
        if (bus_addr == 4'd4 && bus_wdata[2]) begin m_tac = '0; m_hold = 1'b0; end
        if (bus_addr <= 4'd2) begin
          m_byte = bus_wdata[7:0];
          push_cycle(bus_addr == 4'd2 ? 0 : (bus_addr == 4'd1 ? 1 : 2));
        end
      end else if (bus_req && !bus_we && bus_addr == 4'd0 && !cur[6] && !m_rdpend) begin
        push_cycle(3);
        m_rdpend = 1'b1;
      end
      cur = (q.size() > 0) ? q.pop_front() : IDLE_E;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      string tag;
      logic exp_ack;
      logic [14:0] act_v, exp_v;
      tag = !cur[6] ? "R9" : (cur[9:8] == 0 ? "R2" : cur[9:8] == 1 ? "R3" : cur[9:8] == 2 ? "R4" : "R5");
      exp_ack = (bus_req && bus_we && !cur[6]) || (bus_req && !bus_we && bus_addr != 4'd0) || (m_rdpend && cur[7]);
      exp_v = {cur[5], cur[4], cur[3], cur[2], cur[1], !(m_hold || cur[6]), (cur[1] ? m_byte : nand_io_out), exp_ack};
      act_v = {nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe, nand_ce_n, nand_io_out, bus_ack};
      chk({tag, " pins"}, 32'(act_v), 32'(exp_v));
      if (bus_req && bus_we && cur[6]) chk("R8 stall", 32'(bus_ack), 32'd0);
    end
  end

  int t_acc;
  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    #1;
    while (!bus_ack) begin @(negedge clk); #1; end
    t_acc = cyc;
    @(posedge clk); #1;
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1;
    while (!bus_ack) begin @(negedge clk); #1; end
    d = bus_rdata;
    @(posedge clk); #1;
    bus_req = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int t0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset pins", {26'd0, nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale, nand_io_oe},
        {26'd0, 6'b111000});
    chk("R1 reset irq", 32'(irq), 32'd0);
    rst_n = 1'b1;
    idle(4);
    bus_read(4'd6, rd); chk("R1 stat ready", rd, 32'd1);

    // R6 timing: wr wait2 width3 hold1 setup2, rd wait1 width2 hold1 setup3
    bus_write(4'd11, 32'h2312_1213);
    bus_read(4'd11, rd); chk("R6 timing readback", rd, 32'h2312_1213);
    bus_write(4'd2, 32'h0001_FF70);          // R2 command cycle
    bus_read(4'd6, rd); chk("R7 stat busy", rd, 32'd0);
    idle(10);
    bus_write(4'd1, 32'h0000_0012);          // R3 address
    t0 = t_acc;
    bus_write(4'd0, 32'h0000_005A);          // R4 data write, stalled
    chk("R8 back-to-back spacing", 32'(t_acc - t0), 32'd9);
    idle(10);
    nand_io_in = 8'hA5;
    bus_read(4'd0, rd); chk("R5 read byte", rd, 32'h0000_00A5);
    idle(4);

    // R6 zero fields give one clock each
    bus_write(4'd11, 32'h0);
    bus_write(4'd2, 32'h0000_0090);
    t0 = t_acc;
    bus_write(4'd1, 32'h0000_0000);
    chk("R6 zero-field spacing", 32'(t_acc - t0), 32'd4);
    idle(4);

    // R9 chip enable held
    bus_write(4'd5, 32'h0000_0020);
    idle(3);
    chk("R9 ce held idle", 32'(nand_ce_n), 32'd0);
    bus_read(4'd5, rd); chk("R9 cfg readback", rd, 32'h20);
    bus_write(4'd0, 32'h0000_0033);
    bus_write(4'd5, 32'h0);
    idle(3);
    chk("R9 ce released", 32'(nand_ce_n), 32'd1);

    // R10 byte counter
    bus_write(4'd12, 32'd2);
    bus_write(4'd0, 32'h11);
    idle(4);
    bus_read(4'd12, rd); chk("R10 tc after one", rd, 32'd1);
    bus_read(4'd7, rd); chk("R10 flag not yet", rd & 32'h2, 32'd0);
    bus_read(4'd0, rd);
    idle(4);
    bus_read(4'd12, rd); chk("R10 tc zero", rd, 32'd0);
    bus_read(4'd7, rd); chk("R10 flag set", rd & 32'h2, 32'h2);
    bus_write(4'd0, 32'h22);
    idle(4);
    bus_read(4'd12, rd); chk("R10 tc stays zero", rd, 32'd0);

    // R11 mask and clear
    chk("R11 irq masked", 32'(irq), 32'd0);
    bus_write(4'd8, 32'h2);
    @(negedge clk); chk("R11 irq enabled", 32'(irq), 32'd1);
    bus_read(4'd9, rd); chk("R11 masked view", rd, 32'h2);
    bus_write(4'd10, 32'h2);
    @(negedge clk); chk("R11 irq cleared", 32'(irq), 32'd0);
    bus_read(4'd7, rd); chk("R11 status cleared", rd, 32'd0);
    nand_rb = 1'b0;
    idle(4);
    bus_read(4'd6, rd); chk("R7 stat pin busy", rd, 32'd0);
    nand_rb = 1'b1;
    idle(4);
    bus_read(4'd7, rd); chk("R11 ready edge", rd, 32'h1);

    // R12 software reset
    bus_write(4'd5, 32'h3E);
    bus_write(4'd11, 32'h1111_1111);
    bus_write(4'd12, 32'd7);
    bus_write(4'd4, 32'h4);
    bus_read(4'd5, rd);  chk("R12 cfg cleared", rd, 32'd0);
    bus_read(4'd11, rd); chk("R12 timing cleared", rd, 32'd0);
    bus_read(4'd12, rd); chk("R12 tc cleared", rd, 32'd0);
    bus_read(4'd8, rd);  chk("R12 ien cleared", rd, 32'd0);
    bus_read(4'd7, rd);  chk("R12 status cleared", rd, 32'd0);
    bus_read(4'd4, rd);  chk("R12 ctrl reads zero", rd, 32'd0);
    idle(4);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule